// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 48-bit virtual address into a 52-bit physical address. It walks a four-level radix table held in memory, starting from a root frame number supplied on an input. A request carries the virtual address and three access attributes: a store flag, a user-mode flag and an instruction-fetch flag. The walker then issues one 64-bit read per level on a simple request/response memory port. Each entry it reads either points to the next table or, at the last level, names the frame that backs the page.

At the leaf, the walker applies the entry's protection bits to the access. It sets the accessed bit and, for a store, the dirty bit. When either bit changes, it writes the updated entry back to memory before it answers. The response gives either the physical address with the leaf's low flag bits, or a fault. A fault carries a cause code and the level at which the walk stopped.

Only one walk runs at a time. While `busy` is high, new requests are not taken.

Top module: `pt_walker`

## Requirements
- R1: The index used at level n (n=0 top, n=3 leaf) is virtual address bits [47-9n : 39-9n]. The entry address is {table frame, index, 3'b000}, so each entry is 8 bytes. The top table's frame is `root_pfn`.
- R2: A walk that reaches the leaf issues exactly four reads, one at a time. Each non-leaf entry's bits [51:12] give the frame of the next table.
- R3: On success, `rsp_paddr` = {leaf bits [51:12], vaddr[11:0]}, and `rsp_flags` holds bits [11:0] of the leaf as updated.
- R4: An entry with bit 0 (present) clear ends the walk with cause 0 and the level of that entry. No further reads follow, so the walk makes level+1 reads.
- R5: A store to a leaf with bit 1 (writable) clear faults with cause 1 at level 3.
- R6: A user-mode access to a leaf with bit 2 (user) clear faults with cause 2 at level 3. This takes priority over cause 1.
- R7: A fetch from a leaf with bit 63 (no-execute) set faults with cause 3 at level 3. This has the lowest priority.
- R8: On a successful walk, bit 5 (accessed) is set, and bit 6 (dirty) is set on a store. If either bit changes, one 64-bit write of the updated entry goes to the leaf's address before the response. If neither changes, no write is issued.
- R9: A walk that ends in a fault never writes memory.
- R10: `busy` rises in the cycle after a request is accepted and stays high until the response cycle ends. A request presented while `busy` is high is ignored.
- R11: `rsp_valid` is a single-cycle pulse per walk. After reset, `busy`, `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when busy is low) |
| req_vaddr | input | 48 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access is from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| root_pfn | input | 40 | Frame number of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory access strobe (one cycle) |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 52 | Byte address of the entry |
| mem_wdata | output | 64 | Updated entry for write-back |
| mem_rvalid | input | 1 | Read data valid / write acknowledge |
| mem_rdata | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 not present, 1 write-protect, 2 user, 3 no-execute |
| rsp_level | output | 2 | Level of the last entry read |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_flags | output | 12 | Low flag bits of the updated leaf |

## Verification
The walker is driven against a table built in memory whose leaves cover five cases: full rights, read-only, supervisor-only, no-execute and absent. Accesses to these leaves vary in store, user and fetch flags. This separates each fault cause, and the priority between the user and write-protect causes. Absent entries placed at each of the four levels, including one reached through all-ones indices, show where the walk stops and how many reads it made. Repeated accesses to the same leaf tell a first touch, which writes the entry back, from a later touch that finds the accessed and dirty bits already set. A second request held during a walk shows it is ignored.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int VA_W   = 48;
  localparam int PA_W   = 52;
  localparam int PTE_W  = 64;
  localparam int LEVELS = 4;
  localparam int IDX_W  = 9;
  localparam int OFF_W  = 12;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int PFN_W  = PA_W - OFF_W;

  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_USR  = 2;
  localparam int BIT_ACC  = 5;
  localparam int BIT_DRT  = 6;
  localparam int BIT_NOX  = 63;

  typedef enum logic [1:0] {
    CS_ABSENT = 2'd0,
    CS_WPROT  = 2'd1,
    CS_PRIV   = 2'd2,
    CS_NOEXEC = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RDW,
    ST_WB,
    ST_WBW,
    ST_RSP
  } walk_st_e;
endpackage

// File: rtl/pt_index.sv
module pt_index #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LVL_W  = 2
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [LVL_W-1:0]      level,
  input  logic [PA_W-OFF_W-1:0] tbl_pfn,
  output logic [PA_W-1:0]       ent_addr
);
  localparam int SLOT_W = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx_of [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_of[g] = vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign ent_addr = {tbl_pfn, idx_of[level], {SLOT_W{1'b0}}};
endmodule

// File: rtl/pt_check.sv
module pt_check
  import pt_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_leaf,
  input  logic             acc_wr,
  input  logic             acc_usr,
  input  logic             acc_fetch,
  output logic             fault,
  output cause_e           cause,
  output logic [PTE_W-1:0] upd_entry,
  output logic             need_wb
);
  always_comb begin
    upd_entry          = entry;
    upd_entry[BIT_ACC] = 1'b1;
    if (acc_wr) upd_entry[BIT_DRT] = 1'b1;
    need_wb = (upd_entry != entry);

    fault = 1'b0;
    cause = CS_ABSENT;
    if (!entry[BIT_PRES]) begin
      fault = 1'b1;
      cause = CS_ABSENT;
    end else if (is_leaf) begin
      if (acc_usr && !entry[BIT_USR]) begin
        fault = 1'b1;
        cause = CS_PRIV;
      end else if (acc_wr && !entry[BIT_WR]) begin
        fault = 1'b1;
        cause = CS_WPROT;
      end else if (acc_fetch && entry[BIT_NOX]) begin
        fault = 1'b1;
        cause = CS_NOEXEC;
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int P_VA_W   = VA_W,
  parameter int P_PA_W   = PA_W,
  parameter int P_PTE_W  = PTE_W,
  parameter int P_LEVELS = LEVELS,
  parameter int P_IDX_W  = IDX_W,
  parameter int P_OFF_W  = OFF_W,
  parameter int P_LVL_W  = $clog2(P_LEVELS),
  parameter int P_PFN_W  = P_PA_W - P_OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [P_VA_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic               req_fetch,
  input  logic [P_PFN_W-1:0] root_pfn,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [P_PA_W-1:0]  mem_addr,
  output logic [P_PTE_W-1:0] mem_wdata,
  input  logic               mem_rvalid,
  input  logic [P_PTE_W-1:0] mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [P_LVL_W-1:0] rsp_level,
  output logic [P_PA_W-1:0]  rsp_paddr,
  output logic [P_OFF_W-1:0] rsp_flags
);
  localparam logic [P_LVL_W-1:0] LAST_LVL = P_LVL_W'(P_LEVELS - 1);

  walk_st_e           st_q, st_d;
  logic [P_LVL_W-1:0] lvl_q, lvl_d;
  logic [P_PFN_W-1:0] tbl_q, tbl_d;
  logic [P_VA_W-1:0]  va_q;
  logic               wr_q, usr_q, fet_q;
  logic [P_PTE_W-1:0] ent_q, ent_d;
  logic               flt_q, flt_d;
  cause_e             cs_q, cs_d;
  logic               ld_req;

  logic               chk_fault;
  cause_e             chk_cause;
  logic [P_PTE_W-1:0] chk_upd;
  logic               chk_wb;

  pt_index #(
    .VA_W(P_VA_W), .PA_W(P_PA_W), .LEVELS(P_LEVELS),
    .IDX_W(P_IDX_W), .OFF_W(P_OFF_W), .LVL_W(P_LVL_W)
  ) u_index (
    .vaddr   (va_q),
    .level   (lvl_q),
    .tbl_pfn (tbl_q),
    .ent_addr(mem_addr)
  );

  pt_check #(.PTE_W(P_PTE_W)) u_check (
    .entry    (mem_rdata),
    .is_leaf  (lvl_q == LAST_LVL),
    .acc_wr   (wr_q),
    .acc_usr  (usr_q),
    .acc_fetch(fet_q),
    .fault    (chk_fault),
    .cause    (chk_cause),
    .upd_entry(chk_upd),
    .need_wb  (chk_wb)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    tbl_d  = tbl_q;
    ent_d  = ent_q;
    flt_d  = flt_q;
    cs_d   = cs_q;
    ld_req = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          lvl_d  = '0;
          tbl_d  = root_pfn;
          flt_d  = 1'b0;
          cs_d   = CS_ABSENT;
          st_d   = ST_RD;
        end
      end
      ST_RD:  st_d = ST_RDW;
      ST_RDW: begin
        if (mem_rvalid) begin
          if (chk_fault) begin
            flt_d = 1'b1;
            cs_d  = chk_cause;
            ent_d = mem_rdata;
            st_d  = ST_RSP;
          end else if (lvl_q != LAST_LVL) begin
            tbl_d = mem_rdata[P_PA_W-1:P_OFF_W];
            lvl_d = lvl_q + 1'b1;
            st_d  = ST_RD;
          end else begin
            ent_d = chk_upd;
            st_d  = chk_wb ? ST_WB : ST_RSP;
          end
        end
      end
      ST_WB:  st_d = ST_WBW;
      ST_WBW: if (mem_rvalid) st_d = ST_RSP;
      ST_RSP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lvl_q <= '0;
      tbl_q <= '0;
      ent_q <= '0;
      flt_q <= 1'b0;
      cs_q  <= CS_ABSENT;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
      tbl_q <= tbl_d;
      ent_q <= ent_d;
      flt_q <= flt_d;
      cs_q  <= cs_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      wr_q  <= 1'b0;
      usr_q <= 1'b0;
      fet_q <= 1'b0;
    end else if (ld_req) begin
      va_q  <= req_vaddr;
      wr_q  <= req_write;
      usr_q <= req_user;
      fet_q <= req_fetch;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign mem_req   = (st_q == ST_RD) || (st_q == ST_WB);
  assign mem_we    = (st_q == ST_WB);
  assign mem_wdata = ent_q;
  assign rsp_valid = (st_q == ST_RSP);
  assign rsp_fault = flt_q;
  assign rsp_cause = cs_q;
  assign rsp_level = lvl_q;
  assign rsp_paddr = {ent_q[P_PA_W-1:P_OFF_W], va_q[P_OFF_W-1:0]};
  assign rsp_flags = ent_q[P_OFF_W-1:0];
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             mem_req,
  input logic             mem_we,
  input logic [PTE_W-1:0] mem_wdata,
  input logic             rsp_valid,
  input logic             rsp_fault
);
  logic wb_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wb_seen <= 1'b0;
    else if (rsp_valid)          wb_seen <= 1'b0;
    else if (mem_req && mem_we)  wb_seen <= 1'b1;
  end

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R10
  mem_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R2
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  wb_content_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[BIT_PRES] && mem_wdata[BIT_ACC]));

  // R9
  no_wb_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && wb_seen) |-> !rsp_fault);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_wdata(mem_wdata),
  .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_user, req_fetch;
  logic [47:0] req_vaddr;
  logic [39:0] root_pfn;
  logic        busy, mem_req, mem_we, mem_rvalid;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause, rsp_level;
  logic [51:0] rsp_paddr;
  logic [11:0] rsp_flags;

  int total = 0;
  int bad   = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  bit done = 1'b0;
  logic [63:0] mem [logic [51:0]];

  always #2 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
    .root_pfn(root_pfn), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_level(rsp_level), .rsp_paddr(rsp_paddr),
    .rsp_flags(rsp_flags)
  );

  // memory model: one-cycle latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        mem_rvalid <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
          rd_cnt++;
        end
      end
    end
  end

  function automatic logic [47:0] va(input int a, input int b, input int c,
                                     input int d, input int o);
    return {a[8:0], b[8:0], c[8:0], d[8:0], o[11:0]};
  endfunction

  function automatic logic [63:0] pte(input logic nx, input logic [39:0] pfn,
                                      input logic [11:0] fl);
    return {nx, 11'h0, pfn, fl};
  endfunction

  function automatic logic [51:0] ea(input logic [39:0] tbl, input int idx);
    return {tbl, idx[8:0], 3'b000};
  endfunction

  typedef struct packed {
    logic [47:0] v;
    logic        wr, usr, fet, flt;
    logic [1:0]  cause, lvl;
    logic [51:0] pa;
    logic        wb;
  } vec_t;

  // causes: 0 absent, 1 write-protect, 2 user, 3 no-execute
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{va(1,2,3,0,'h5D6), 1'b0,1'b1,1'b0, 1'b0,2'd0,2'd3, {40'hABCDE,12'h5D6}, 1'b1},
    '{va(1,2,3,0,'h008), 1'b1,1'b1,1'b0, 1'b0,2'd0,2'd3, {40'hABCDE,12'h008}, 1'b1},
    '{va(1,2,3,1,'h100), 1'b1,1'b1,1'b0, 1'b1,2'd1,2'd3, 52'h0, 1'b0},
    '{va(1,2,3,1,'h104), 1'b0,1'b1,1'b0, 1'b0,2'd0,2'd3, {40'h11111,12'h104}, 1'b1},
    '{va(1,2,3,2,'h000), 1'b0,1'b1,1'b0, 1'b1,2'd2,2'd3, 52'h0, 1'b0},
    '{va(1,2,3,2,'hFFF), 1'b1,1'b0,1'b0, 1'b0,2'd0,2'd3, {40'h22222,12'hFFF}, 1'b1},
    '{va(1,2,3,3,'h010), 1'b0,1'b1,1'b1, 1'b1,2'd3,2'd3, 52'h0, 1'b0},
    '{va(1,2,3,3,'h020), 1'b0,1'b1,1'b0, 1'b0,2'd0,2'd3, {40'h33333,12'h020}, 1'b1},
    '{va(1,2,3,4,'h000), 1'b0,1'b1,1'b0, 1'b1,2'd0,2'd3, 52'h0, 1'b0},
    '{va(5,0,0,0,'h000), 1'b0,1'b1,1'b0, 1'b1,2'd0,2'd0, 52'h0, 1'b0},
    '{va(1,7,0,0,'h000), 1'b0,1'b1,1'b0, 1'b1,2'd0,2'd1, 52'h0, 1'b0},
    '{va(1,2,9,0,'h000), 1'b0,1'b1,1'b0, 1'b1,2'd0,2'd2, 52'h0, 1'b0},
    '{va(1,2,3,5,'hABC), 1'b1,1'b1,1'b0, 1'b0,2'd0,2'd3, {40'h55555,12'hABC}, 1'b0},
    '{va(1,2,3,6,'h000), 1'b1,1'b1,1'b0, 1'b1,2'd2,2'd3, 52'h0, 1'b0},
    '{va(1,2,3,0,'h001), 1'b1,1'b1,1'b0, 1'b0,2'd0,2'd3, {40'hABCDE,12'h001}, 1'b0},
    '{va(511,511,0,0,0), 1'b0,1'b0,1'b0, 1'b1,2'd0,2'd1, 52'h0, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [47:0] v, input logic w, input logic u,
                      input logic f, output bit seen);
    int n;
    @(negedge clk);
    req_vaddr = v; req_write = w; req_user = u; req_fetch = f;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    seen = rsp_valid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    int r0, w0;
    string tg;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0; req_fetch = 1'b0;
    req_vaddr = '0;
    root_pfn  = 40'h1;
    // table tree: top @0x1000, mid @0x2000, low @0x3000, leaves @0x4000
    mem[ea(40'h1, 1)]   = pte(1'b0, 40'h2, 12'h007);
    mem[ea(40'h1, 511)] = pte(1'b0, 40'h5, 12'h007);
    mem[ea(40'h2, 2)]   = pte(1'b0, 40'h3, 12'h007);
    mem[ea(40'h3, 3)]   = pte(1'b0, 40'h4, 12'h007);
    mem[ea(40'h4, 0)]   = pte(1'b0, 40'hABCDE, 12'h007);
    mem[ea(40'h4, 1)]   = pte(1'b0, 40'h11111, 12'h005);
    mem[ea(40'h4, 2)]   = pte(1'b0, 40'h22222, 12'h003);
    mem[ea(40'h4, 3)]   = pte(1'b1, 40'h33333, 12'h007);
    mem[ea(40'h4, 5)]   = pte(1'b0, 40'h55555, 12'h067);
    mem[ea(40'h4, 6)]   = pte(1'b0, 40'h66666, 12'h001);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy after reset", 64'(busy), 64'h0);
    chk("R11 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    chk("R11 mem_req after reset", 64'(mem_req), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      r0 = rd_cnt; w0 = wr_cnt;
      walk(VECS[i].v, VECS[i].wr, VECS[i].usr, VECS[i].fet, seen);
      chk($sformatf("R11 response seen vec%0d", i), 64'(seen), 64'h1);
      chk($sformatf("R2 read count vec%0d (R1 indices)", i), 64'(rd_cnt - r0),
          VECS[i].flt ? 64'(VECS[i].lvl) + 64'd1 : 64'd4);
      chk($sformatf("R4-R7 fault flag vec%0d", i), 64'(rsp_fault), 64'(VECS[i].flt));
      if (VECS[i].flt) begin
        case (VECS[i].cause)
          2'd0: tg = "R4"; 2'd1: tg = "R5"; 2'd2: tg = "R6"; default: tg = "R7";
        endcase
        chk($sformatf("%s cause vec%0d", tg, i), 64'(rsp_cause), 64'(VECS[i].cause));
        chk($sformatf("%s level vec%0d", tg, i), 64'(rsp_level), 64'(VECS[i].lvl));
        chk($sformatf("R9 no write on fault vec%0d", i), 64'(wr_cnt - w0), 64'h0);
      end else begin
        chk($sformatf("R3 paddr vec%0d", i), 64'(rsp_paddr), 64'(VECS[i].pa));
        chk($sformatf("R8 accessed flag vec%0d", i), 64'(rsp_flags[5]), 64'h1);
        if (VECS[i].wr)
          chk($sformatf("R8 dirty flag vec%0d", i), 64'(rsp_flags[6]), 64'h1);
        chk($sformatf("R8 write count vec%0d", i), 64'(wr_cnt - w0), 64'(VECS[i].wb));
      end
    end

    // R8 written-back contents
    chk("R8 leaf0 after stores", mem[ea(40'h4, 0)], pte(1'b0, 40'hABCDE, 12'h067));
    chk("R8 leaf3 read only sets A", mem[ea(40'h4, 3)], pte(1'b1, 40'h33333, 12'h027));
    chk("R3 flags of leaf1 after read", mem[ea(40'h4, 1)], pte(1'b0, 40'h11111, 12'h025));
    // R9 faulting leaf untouched
    chk("R9 leaf6 unchanged", mem[ea(40'h4, 6)], pte(1'b0, 40'h66666, 12'h001));

    // R10 request during busy is ignored
    r0 = rd_cnt;
    @(negedge clk);
    req_vaddr = va(1,2,3,5,'h123); req_write = 1'b0; req_user = 1'b1; req_fetch = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    chk("R10 busy after accept", 64'(busy), 64'h1);
    req_vaddr = va(5,0,0,0,0);
    begin
      int n = 0;
      while (!rsp_valid && n < 200) begin
        @(negedge clk);
        chk("R10 busy held during walk", 64'(busy), 64'h1);
        n++;
      end
    end
    req_valid = 1'b0;
    chk("R10 first request answered", 64'(rsp_fault), 64'h0);
    chk("R10 paddr of first request", 64'(rsp_paddr), 64'({40'h55555, 12'h123}));
    chk("R10 reads of one walk", 64'(rd_cnt - r0), 64'd4);
    @(negedge clk);
    chk("R11 response one cycle", 64'(rsp_valid), 64'h0);
    r0 = rd_cnt;
    repeat (10) @(negedge clk);
    chk("R10 ignored request issued nothing", 64'(rd_cnt - r0), 64'h0);
    chk("R10 idle after response", 64'(busy), 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule